// File: doc/BRIEF.md
# RNS Reduction Coefficient Estimator

This block sits beside the channel datapath of a residue-number-system modular multiplier. It takes the eight per-channel values gamma_i, which are already reduced by each channel's modulus, and derives the two integer corrections that turn a sum of residues into an exact remainder modulo a field prime p. The first correction, alpha, counts how many times the plain sum of weighted channel values went past the RNS dynamic range. It is estimated from a coarse fixed-point sum. The second correction, kappa, is the multiple of p that the channel datapath must still subtract. It comes from short products of gamma_i with a per-channel constant C_i, followed by a fixed right shift. Because kappa is smaller than every channel modulus, the channel logic can use it directly as its own residue.

A caller writes the eight constants C_i once through a small load port. It then presents a full gamma vector with a one-cycle start strobe. The block captures the vector and works through one channel per clock. It presents alpha and kappa together with a one-cycle done pulse, and holds both results until the next operation ends.

Top module: `rns_coef_estimator`

## Requirements
- R1: While reset is high, and in the first cycle after it, done is 0, alpha is 0 and kappa is 0.
- R2: A start that is accepted while the block is idle produces exactly one done pulse, one cycle wide, in the cycle after the (NUM_CH+1)-th rising edge that follows the accepting edge.
- R3: At done, alpha equals floor((S + 16) / 256). S is the sum over all channels of the top 8 bits (bits 65..58) of each 66-bit gamma_i. Channel i sits at bits [66*i+65 : 66*i] of gammaIn.
- R4: When that quotient exceeds NUM_CH-1, for input outside the valid range, alpha saturates to NUM_CH-1 (7).
- R5: At done, kappa equals floor((sum over i of gamma_i * C_i) / 2^72), computed without overflow for any 66-bit gamma_i and 55-bit C_i, and delivered as 52 bits.
- R6: A start that arrives while an operation is in progress is ignored. It does not change the running result and does not create an extra done pulse.
- R7: A constant write with cLoadEn high while idle stores cLoadVal as C for channel cLoadIdx, and later operations use it. A write while busy is ignored.
- R8: A start asserted in the same cycle that done is high is accepted, so that operations can run back to back.
- R9: Between done pulses, alpha and kappa hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe; gammaIn is captured on the accepting edge |
| gammaIn | input | 528 | Eight 66-bit channel values, channel 0 in the low bits |
| cLoadEn | input | 1 | Constant write enable |
| cLoadIdx | input | 3 | Channel index of the constant write |
| cLoadVal | input | 55 | Constant C value to write |
| done | output | 1 | One-cycle result-valid pulse |
| alpha | output | 3 | Range-overflow coefficient |
| kappa | output | 52 | Multiple of p to remove |

## Verification
Three functions can fall in the same cycle. The first is the done pulse of one operation together with the start of the next: the bench raises start exactly in the cycle where it sees done, and expects a second pulse NUM_CH+1 cycles later carrying the second vector's results. The second is a constant write together with an operation in flight: the bench writes a new C while busy and expects the following run to use the old value. The third is a start during a run, which must neither move the pending done nor change its values. A behavioural model checks done, alpha and kappa on every cycle, with full-precision sums.

// File: rtl/rns_coef_pkg.sv
package rns_coef_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } coefState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch the gamma vector, preset the accumulators
    logic accum;     // add one channel's terms
    logic finalize;  // form alpha and kappa, raise done
    logic busy;      // an operation is in flight
  } coefStrobes_t;

endpackage

// File: rtl/rns_coef_ctrl.sv
module rns_coef_ctrl
  import rns_coef_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output coefStrobes_t     strobe,
  output logic [IDX_W-1:0] chIdx
);

  coefState_t       state;
  logic [IDX_W-1:0] chCnt;

  always_comb begin
    strobe.capture  = (state == ST_IDLE) && start;
    strobe.accum    = (state == ST_RUN);
    strobe.finalize = (state == ST_FIN);
    strobe.busy     = (state != ST_IDLE);
    chIdx           = chCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      chCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          chCnt <= '0;
          if (start) state <= ST_RUN;
        end
        ST_RUN: begin
          if (chCnt == IDX_W'(NUM_CH - 1)) begin
            state <= ST_FIN;
            chCnt <= '0;
          end else begin
            chCnt <= chCnt + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rns_coef_datapath.sv
module rns_coef_datapath
  import rns_coef_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int CH_W         = 66,
  parameter int ALPHA_Q      = 8,
  parameter int ALPHA_OFFSET = 16,
  parameter int CONST_W      = 55,
  parameter int KAPPA_SHIFT  = 72,
  localparam int IDX_W       = $clog2(NUM_CH),
  localparam int ALPHA_W     = IDX_W,
  localparam int ALPHA_ACC_W = ALPHA_Q + IDX_W + 1,
  localparam int QUOT_W      = ALPHA_ACC_W - ALPHA_Q,
  localparam int KACC_W      = CH_W + CONST_W + IDX_W,
  localparam int KAPPA_W     = KACC_W - KAPPA_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  coefStrobes_t           strobe,
  input  logic [IDX_W-1:0]       chIdx,
  input  logic [NUM_CH*CH_W-1:0] gammaIn,
  input  logic                   cLoadEn,
  input  logic [IDX_W-1:0]       cLoadIdx,
  input  logic [CONST_W-1:0]     cLoadVal,
  output logic                   done,
  output logic [ALPHA_W-1:0]     alpha,
  output logic [KAPPA_W-1:0]     kappa
);

  logic [CH_W-1:0]    gammaReg [NUM_CH];
  logic [CONST_W-1:0] constReg [NUM_CH];

  // Per-channel capture of gamma and constant write
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        gammaReg[i] <= '0;
        constReg[i] <= '0;
      end else begin
        if (strobe.capture) gammaReg[i] <= gammaIn[i*CH_W +: CH_W];
        if (cLoadEn && !strobe.busy && (cLoadIdx == IDX_W'(i)))
          constReg[i] <= cLoadVal;
      end
    end
  end

  logic [ALPHA_ACC_W-1:0] alphaAcc;
  logic [KACC_W-1:0]      kappaAcc;
  logic [ALPHA_ACC_W-1:0] alphaTerm;
  logic [KACC_W-1:0]      kappaTerm;
  logic [QUOT_W-1:0]      alphaQuot;
  logic [ALPHA_W-1:0]     alphaNext;

  always_comb begin
    alphaTerm = ALPHA_ACC_W'(gammaReg[chIdx][CH_W-1 -: ALPHA_Q]);
    kappaTerm = KACC_W'(gammaReg[chIdx]) * KACC_W'(constReg[chIdx]);
    alphaQuot = alphaAcc[ALPHA_ACC_W-1:ALPHA_Q];
    if (alphaQuot > QUOT_W'(NUM_CH - 1)) alphaNext = ALPHA_W'(NUM_CH - 1);
    else                                 alphaNext = alphaQuot[ALPHA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alphaAcc <= '0;
      kappaAcc <= '0;
      done     <= 1'b0;
      alpha    <= '0;
      kappa    <= '0;
    end else begin
      done <= strobe.finalize;
      if (strobe.capture) begin
        alphaAcc <= ALPHA_ACC_W'(ALPHA_OFFSET);
        kappaAcc <= '0;
      end else if (strobe.accum) begin
        alphaAcc <= alphaAcc + alphaTerm;
        kappaAcc <= kappaAcc + kappaTerm;
      end
      if (strobe.finalize) begin
        alpha <= alphaNext;
        kappa <= kappaAcc[KACC_W-1 -: KAPPA_W];
      end
    end
  end

endmodule

// File: rtl/rns_coef_estimator.sv
module rns_coef_estimator
  import rns_coef_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int CH_W         = 66,
  parameter int ALPHA_Q      = 8,
  parameter int ALPHA_OFFSET = 16,
  parameter int CONST_W      = 55,
  parameter int KAPPA_SHIFT  = 72,
  localparam int IDX_W       = $clog2(NUM_CH),
  localparam int ALPHA_W     = IDX_W,
  localparam int KAPPA_W     = CH_W + CONST_W + IDX_W - KAPPA_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [NUM_CH*CH_W-1:0] gammaIn,
  input  logic                   cLoadEn,
  input  logic [IDX_W-1:0]       cLoadIdx,
  input  logic [CONST_W-1:0]     cLoadVal,
  output logic                   done,
  output logic [ALPHA_W-1:0]     alpha,
  output logic [KAPPA_W-1:0]     kappa
);

  coefStrobes_t     strobe;
  logic [IDX_W-1:0] chIdx;

  rns_coef_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe),
    .chIdx  (chIdx)
  );

  rns_coef_datapath #(
    .NUM_CH       (NUM_CH),
    .CH_W         (CH_W),
    .ALPHA_Q      (ALPHA_Q),
    .ALPHA_OFFSET (ALPHA_OFFSET),
    .CONST_W      (CONST_W),
    .KAPPA_SHIFT  (KAPPA_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .chIdx    (chIdx),
    .gammaIn  (gammaIn),
    .cLoadEn  (cLoadEn),
    .cLoadIdx (cLoadIdx),
    .cLoadVal (cLoadVal),
    .done     (done),
    .alpha    (alpha),
    .kappa    (kappa)
  );

endmodule

// File: rtl/rns_coef_estimator_chk.sv
module rns_coef_estimator_chk #(
  parameter int NUM_CH  = 8,
  parameter int ALPHA_W = 3,
  parameter int KAPPA_W = 52,
  localparam int CNT_W  = $clog2(NUM_CH + 2)
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               done,
  input logic [ALPHA_W-1:0] alpha,
  input logic [KAPPA_W-1:0] kappa
);

  // Independent tracker of the operation window seen from the ports
  logic             ckBusy;
  logic [CNT_W-1:0] ckCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ckBusy <= 1'b0;
      ckCnt  <= '0;
    end else if (!ckBusy && start) begin
      ckBusy <= 1'b1;
      ckCnt  <= '0;
    end else if (ckBusy) begin
      ckCnt <= ckCnt + 1'b1;
      if (ckCnt == CNT_W'(NUM_CH)) ckBusy <= 1'b0;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!done && alpha == '0 && kappa == '0));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_timing_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ckBusy && ckCnt == CNT_W'(NUM_CH + 1)));

  assert_done_due_R2: assert property (@(posedge clk) disable iff (rst)
    (ckBusy && ckCnt == CNT_W'(NUM_CH)) |=> done);

  assert_busy_start_R6: assert property (@(posedge clk) disable iff (rst)
    (ckBusy && start && ckCnt < CNT_W'(NUM_CH)) |=> !done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(alpha) && $stable(kappa)));

endmodule

bind rns_coef_estimator rns_coef_estimator_chk #(
  .NUM_CH  (NUM_CH),
  .ALPHA_W (ALPHA_W),
  .KAPPA_W (KAPPA_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .done  (done),
  .alpha (alpha),
  .kappa (kappa)
);

// File: tb/rns_coef_estimator_tb.sv
`timescale 1ns/1ps
module rns_coef_estimator_tb;

  localparam int N  = 8;
  localparam int CW = 66;
  localparam int KW = 55;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [N*CW-1:0] gammaIn = '0;
  logic            cLoadEn = 1'b0;
  logic [2:0]      cLoadIdx = '0;
  logic [KW-1:0]   cLoadVal = '0;
  logic            done;
  logic [2:0]      alpha;
  logic [51:0]     kappa;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  rns_coef_estimator u_dut (
    .clk(clk), .rst(rst), .start(start), .gammaIn(gammaIn),
    .cLoadEn(cLoadEn), .cLoadIdx(cLoadIdx), .cLoadVal(cLoadVal),
    .done(done), .alpha(alpha), .kappa(kappa)
  );

  // Behavioural reference model, updated at each rising edge
  logic [KW-1:0] mC [N];
  logic          mBusy = 1'b0;
  logic          mDone = 1'b0;
  int            mLeft = 0;
  logic [2:0]    mAlpha = '0, pendA = '0;
  logic [51:0]   mKappa = '0, pendK = '0;

  always @(posedge clk) begin
    if (rst) begin
      mBusy = 1'b0; mDone = 1'b0; mLeft = 0;
      mAlpha = '0; mKappa = '0;
      for (int i = 0; i < N; i++) mC[i] = '0;
    end else begin
      logic wasBusy;
      wasBusy = mBusy;
      mDone = 1'b0;
      if (cLoadEn && !wasBusy) mC[cLoadIdx] = cLoadVal;
      if (wasBusy) begin
        mLeft--;
        if (mLeft == 0) begin
          mBusy = 1'b0; mDone = 1'b1; mAlpha = pendA; mKappa = pendK;
        end
      end else if (start) begin
        int s;
        int q;
        logic [127:0] acc;
        s = 16; acc = '0;
        for (int i = 0; i < N; i++) begin
          s += int'(gammaIn[i*CW + CW - 1 -: 8]);
          acc += 128'(gammaIn[i*CW +: CW]) * 128'(mC[i]);
        end
        q = s / 256;
        pendA = (q > N - 1) ? 3'(N - 1) : 3'(q);
        pendK = 52'(acc >> 72);
        mBusy = 1'b1; mLeft = N + 1;
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (done !== mDone) begin
        failures++;
        $display("FAIL R2 %s done actual=%0b expected=%0b", phase, done, mDone);
      end
      checks++;
      if (alpha !== mAlpha) begin
        failures++;
        $display("FAIL %s %s alpha actual=%0d expected=%0d",
                 mDone ? "R3/R4" : "R9", phase, alpha, mAlpha);
      end
      checks++;
      if (kappa !== mKappa) begin
        failures++;
        $display("FAIL %s %s kappa actual=%0h expected=%0h",
                 mDone ? "R5" : "R9", phase, kappa, mKappa);
      end
    end
  end

  task automatic loadConst(input int idx, input logic [KW-1:0] v);
    @(negedge clk);
    cLoadEn = 1'b1; cLoadIdx = 3'(idx); cLoadVal = v;
    @(negedge clk);
    cLoadEn = 1'b0;
  endtask

  task automatic pulseStart(input logic [N*CW-1:0] g);
    @(negedge clk);
    gammaIn = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runOp(input logic [N*CW-1:0] g);
    pulseStart(g);
    repeat (N + 3) @(negedge clk);
  endtask

  function automatic logic [CW-1:0] rnd66();
    return CW'({$urandom, $urandom, $urandom});
  endfunction

  function automatic logic [N*CW-1:0] rndVec();
    logic [N*CW-1:0] v;
    for (int i = 0; i < N; i++) v[i*CW +: CW] = rnd66();
    return v;
  endfunction

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N*CW-1:0] g;
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || alpha !== '0 || kappa !== '0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%0b/%0d/%0h expected=0/0/0", done, alpha, kappa);
    end
    rst = 1'b0;

    // R7: load the constants while idle
    phase = "R7";
    for (int i = 0; i < N; i++) loadConst(i, KW'({$urandom, $urandom}));

    // R3, R5: all-zero vector
    phase = "R3 zero";
    runOp('0);

    // R3: alpha boundary, top byte sum 240 then 239
    phase = "R3 edge";
    g = '0; g[CW-1 -: 8] = 8'd240; runOp(g);
    g = '0; g[CW-1 -: 8] = 8'd239; runOp(g);

    // R5: random patterns
    phase = "R5 random";
    for (int k = 0; k < 6; k++) runOp(rndVec());

    // R4, R5: all-maximum gamma with all-maximum constants
    phase = "R4 max";
    for (int i = 0; i < N; i++) loadConst(i, '1);
    runOp('1);

    // R6: start while busy is ignored
    phase = "R6";
    pulseStart(rndVec());
    repeat (2) @(negedge clk);
    pulseStart(rndVec());
    repeat (N + 3) @(negedge clk);

    // R8: start in the done cycle
    phase = "R8";
    gammaIn = rndVec(); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int w = 0; w < 20 && done !== 1'b1; w++) @(negedge clk);
    gammaIn = rndVec(); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (N + 3) @(negedge clk);

    // R7: a constant write while busy is ignored
    phase = "R7 busy";
    pulseStart(rndVec());
    loadConst(0, 55'h1);
    repeat (N + 2) @(negedge clk);
    g = '0; g[CW-1:0] = '1; runOp(g);

    // R9: outputs hold through idle cycles
    phase = "R9";
    repeat (5) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule